// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two levels of state. The first level is a record of recent branch outcomes. A parameter chooses between a single shared shift register for all branches and a small table of per-branch history registers, selected by low PC bits. The second level is a table of 2-bit saturating counters. The PC bits and the history are combined to index it, either by concatenation or by XOR, as a second parameter chooses.

A fetch stage presents a PC on the predict port. One cycle later it receives a taken/not-taken guess and the counter index that was used. When the branch resolves, the pipeline returns that index with the PC and the real outcome on the update port. The addressed counter moves one step toward the outcome, and the outcome is shifted into the relevant history register.

Top module: `bp2l_predictor`

## Requirements
- R1: When `pred_valid` is high in a cycle, `pred_rdy_o` is high in the next cycle together with `pred_taken_o` and `pred_idx_o`. When `pred_valid` is low, `pred_rdy_o` is low in the next cycle.
- R2: `pred_taken_o` is 1 when the indexed counter holds 2 or 3, and 0 when it holds 0 or 1.
- R3: An update with `upd_taken`=1 raises the counter at `upd_idx` by one. An update with `upd_taken`=0 lowers it by one.
- R4: Counters saturate. They never go above 3 or below 0, and they do not wrap.
- R5: Each update shifts `upd_taken` into bit 0 of a history register, and the older bits move one place up. In global mode (`HIST_MODE`=0) this is the single shared register. In per-branch mode (`HIST_MODE`=1) it is the entry selected by `upd_pc[PC_LSB +: LHT_IDX_W]`. A prediction reads the shared register, or the entry selected by `pred_pc[PC_LSB +: LHT_IDX_W]`.
- R6: The PC field is `pred_pc[PC_LSB +: PC_BITS]`. With `IDX_MODE`=0, the counter index is {PC field, history}, with the history in the low bits. With `IDX_MODE`=1, it is the PC field XOR the history, each zero-extended to the wider of the two.
- R7: After reset, every counter holds 1, every history register holds 0, and `pred_rdy_o` is 0.
- R8: An update modifies the counter at the supplied `upd_idx`, whatever the value of `upd_pc`.
- R9: When a prediction and an update occur in the same cycle, the prediction sees the counters and history as they were before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | Prediction request |
| pred_pc | input | PC_W | PC of the branch to predict |
| pred_rdy_o | output | 1 | Prediction result valid (one cycle after the request) |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_idx_o | output | IDX_W | Counter index used for the prediction |
| upd_valid | input | 1 | Update request |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| upd_idx | input | IDX_W | Counter index returned from the prediction |

## Verification
The embedded properties check on every cycle:
- the one-cycle response timing;
- the single-step movement of a counter on each update;
- the clamping of a counter at both ends of its range;
- the shift of the outcome into the shared history register.

The index formation, the read-before-write ordering when both ports are active, the reset contents and the per-branch history selection only show up in the bench. The bench drives directed sequences that push counters past both limits and random traffic into a reference model. It runs this against a global/concatenation build and a per-branch/XOR build.

// File: rtl/bp2l_pkg.sv
package bp2l_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'd1;

  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    if (taken) return (c == 2'd3) ? c : c + 2'd1;
    else       return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/bp2l_history.sv
module bp2l_history #(
  parameter int HIST_W    = 5,
  parameter int HIST_MODE = 0,
  parameter int LHT_IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LHT_IDX_W-1:0] rd_sel,
  output logic [HIST_W-1:0]    rd_hist,
  input  logic                 upd_valid,
  input  logic [LHT_IDX_W-1:0] upd_sel,
  input  logic                 upd_taken
);
  localparam int LHT_DEPTH = 1 << LHT_IDX_W;

  generate
    if (HIST_MODE == 0) begin : g_global
      logic [HIST_W-1:0] ghr_q;
      logic              unused_sel;
      assign unused_sel = ^{rd_sel, upd_sel};

      always_ff @(posedge clk) begin
        if (rst)            ghr_q <= '0;
        else if (upd_valid) ghr_q <= {ghr_q[HIST_W-2:0], upd_taken};
      end
      assign rd_hist = ghr_q;

      // R5: outcome enters at bit 0, older bits move up
      p_ghr_shift_r5: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> ghr_q == {$past(ghr_q[HIST_W-2:0]), $past(upd_taken)});
    end else begin : g_local
      logic [HIST_W-1:0] lht_q [LHT_DEPTH];
      logic [HIST_W-1:0] upd_old;
      assign upd_old = lht_q[upd_sel];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < LHT_DEPTH; i++) lht_q[i] <= '0;
        end else if (upd_valid) begin
          lht_q[upd_sel] <= {upd_old[HIST_W-2:0], upd_taken};
        end
      end
      assign rd_hist = lht_q[rd_sel];

      // R5: selected entry shifts in the outcome
      p_lht_shift_r5: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> lht_q[$past(upd_sel)] == {$past(upd_old[HIST_W-2:0]), $past(upd_taken)});
    end
  endgenerate
endmodule

// File: rtl/bp2l_index.sv
module bp2l_index #(
  parameter int PC_BITS  = 5,
  parameter int HIST_W   = 5,
  parameter int IDX_MODE = 0,
  parameter int IDX_W    = 10
) (
  input  logic [PC_BITS-1:0] pc_field,
  input  logic [HIST_W-1:0]  hist,
  output logic [IDX_W-1:0]   idx
);
  generate
    if (IDX_MODE == 0) begin : g_concat
      assign idx = {pc_field, hist};
    end else begin : g_xor
      assign idx = IDX_W'(pc_field) ^ IDX_W'(hist);
    end
  endgenerate
endmodule

// File: rtl/bp2l_pht.sv
module bp2l_pht
  import bp2l_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld_o,
  output logic             rd_taken_o,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem_q [DEPTH];
  ctr_t upd_old;
  assign upd_old = mem_q[upd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= CTR_INIT;
      rd_vld_o   <= 1'b0;
      rd_taken_o <= 1'b0;
      rd_idx_o   <= '0;
    end else begin
      rd_vld_o <= rd_en;
      if (rd_en) begin
        rd_taken_o <= ctr_says_taken(mem_q[rd_idx]);
        rd_idx_o   <= rd_idx;
      end
      if (upd_valid) mem_q[upd_idx] <= ctr_step(upd_old, upd_taken);
    end
  end

  // R3: one step up or down
  p_ctr_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken && upd_old != 2'd3) |=> mem_q[$past(upd_idx)] == $past(upd_old) + 2'd1);
  p_ctr_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken && upd_old != 2'd0) |=> mem_q[$past(upd_idx)] == $past(upd_old) - 2'd1);
  // R4: no wrap at either end
  p_ctr_sat_hi_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken && upd_old == 2'd3) |=> mem_q[$past(upd_idx)] == 2'd3);
  p_ctr_sat_lo_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken && upd_old == 2'd0) |=> mem_q[$past(upd_idx)] == 2'd0);
endmodule

// File: rtl/bp2l_predictor.sv
module bp2l_predictor #(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int PC_BITS   = 5,
  parameter int HIST_W    = 5,
  parameter int HIST_MODE = 0,
  parameter int IDX_MODE  = 0,
  parameter int LHT_IDX_W = 4,
  localparam int IDX_W = (IDX_MODE == 0) ? (PC_BITS + HIST_W)
                       : ((PC_BITS > HIST_W) ? PC_BITS : HIST_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pred_valid,
  input  logic [PC_W-1:0]  pred_pc,
  output logic             pred_rdy_o,
  output logic             pred_taken_o,
  output logic [IDX_W-1:0] pred_idx_o,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_taken,
  input  logic [IDX_W-1:0] upd_idx
);
  logic [HIST_W-1:0] rd_hist;
  logic [IDX_W-1:0]  rd_idx;
  logic              unused_pc;
  assign unused_pc = ^{pred_pc, upd_pc};

  bp2l_history #(
    .HIST_W(HIST_W), .HIST_MODE(HIST_MODE), .LHT_IDX_W(LHT_IDX_W)
  ) u_hist (
    .clk       (clk),
    .rst       (rst),
    .rd_sel    (pred_pc[PC_LSB +: LHT_IDX_W]),
    .rd_hist   (rd_hist),
    .upd_valid (upd_valid),
    .upd_sel   (upd_pc[PC_LSB +: LHT_IDX_W]),
    .upd_taken (upd_taken)
  );

  bp2l_index #(
    .PC_BITS(PC_BITS), .HIST_W(HIST_W), .IDX_MODE(IDX_MODE), .IDX_W(IDX_W)
  ) u_idx (
    .pc_field (pred_pc[PC_LSB +: PC_BITS]),
    .hist     (rd_hist),
    .idx      (rd_idx)
  );

  bp2l_pht #(.IDX_W(IDX_W)) u_pht (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (pred_valid),
    .rd_idx     (rd_idx),
    .rd_vld_o   (pred_rdy_o),
    .rd_taken_o (pred_taken_o),
    .rd_idx_o   (pred_idx_o),
    .upd_valid  (upd_valid),
    .upd_idx    (upd_idx),
    .upd_taken  (upd_taken)
  );

  // R1: response exactly one cycle after the request
  p_pred_lat_r1: assert property (@(posedge clk) disable iff (rst)
    pred_valid |=> pred_rdy_o);
  p_pred_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !pred_valid |=> !pred_rdy_o);
endmodule

// File: tb/bp2l_predictor_tb.sv
module bp2l_predictor_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pred_valid = 1'b0;
  logic [31:0] pred_pc = '0;
  logic       upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic       upd_taken = 1'b0;
  logic [9:0] upd_idx = '0;

  logic       g_rdy, g_taken;
  logic [9:0] g_idx;
  logic       l_rdy, l_taken;
  logic [4:0] l_idx;

  always #5 clk = ~clk;

  // global history, concatenated index
  bp2l_predictor u_dut (
    .clk(clk), .rst(rst), .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_rdy_o(g_rdy), .pred_taken_o(g_taken), .pred_idx_o(g_idx),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_idx(upd_idx)
  );

  // per-branch history, XOR index
  bp2l_predictor #(.HIST_MODE(1), .IDX_MODE(1)) u_dut_loc (
    .clk(clk), .rst(rst), .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_rdy_o(l_rdy), .pred_taken_o(l_taken), .pred_idx_o(l_idx),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_idx(upd_idx[4:0])
  );

  // reference model
  logic [1:0] pht_g [1024];
  logic [1:0] pht_l [32];
  logic [4:0] ghr_m;
  logic [4:0] lht_m [16];

  int n_chk  = 0;
  int n_fail = 0;

  bit         have_pend = 0;
  bit         p_pv = 0;
  string      p_tag = "";
  logic [9:0] eg_idx; logic eg_t;
  logic [4:0] el_idx; logic el_t;

  function automatic logic [1:0] nxt(input logic [1:0] c, input logic t);
    if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  function automatic logic [9:0] idx_g(input logic [31:0] pc);
    return {pc[6:2], ghr_m};
  endfunction

  function automatic logic [4:0] idx_l(input logic [31:0] pc);
    return pc[6:2] ^ lht_m[pc[5:2]];
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // called at a falling edge
  task automatic step(input bit pv, input logic [31:0] ppc, input bit uv,
                      input logic [31:0] upc, input bit ut, input logic [9:0] uidx,
                      input string tag);
    if (have_pend) begin
      chk(g_rdy == p_pv, {p_tag, " R1"}, "glob rdy", 32'(g_rdy), 32'(p_pv));
      chk(l_rdy == p_pv, {p_tag, " R1"}, "loc rdy", 32'(l_rdy), 32'(p_pv));
      if (p_pv) begin
        chk(g_idx == eg_idx, {p_tag, " R6"}, "glob idx", 32'(g_idx), 32'(eg_idx));
        chk(g_taken == eg_t, {p_tag, " R2"}, "glob taken", 32'(g_taken), 32'(eg_t));
        chk(l_idx == el_idx, {p_tag, " R5"}, "loc idx", 32'(l_idx), 32'(el_idx));
        chk(l_taken == el_t, {p_tag, " R2"}, "loc taken", 32'(l_taken), 32'(el_t));
      end
    end
    // R9: expectation taken from the state before this cycle's update
    p_pv  = pv;
    p_tag = tag;
    if (pv) begin
      eg_idx = idx_g(ppc);
      eg_t   = pht_g[eg_idx][1];
      el_idx = idx_l(ppc);
      el_t   = pht_l[el_idx][1];
    end
    if (uv) begin
      pht_g[uidx]      = nxt(pht_g[uidx], ut);
      pht_l[uidx[4:0]] = nxt(pht_l[uidx[4:0]], ut);
      ghr_m            = {ghr_m[3:0], ut};
      lht_m[upc[5:2]]  = {lht_m[upc[5:2]][3:0], ut};
    end
    pred_valid = pv; pred_pc = ppc;
    upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_idx = uidx;
    have_pend = 1;
    @(negedge clk);
  endtask

  localparam logic [31:0] PC_A = 32'h0000_0040; // PC field 16

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) pht_g[i] = 2'd1;
    for (int i = 0; i < 32; i++)   pht_l[i] = 2'd1;
    for (int i = 0; i < 16; i++)   lht_m[i] = '0;
    ghr_m = '0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: no response after reset
    chk(g_rdy == 1'b0, "R7", "glob rdy after reset", 32'(g_rdy), 0);
    chk(l_rdy == 1'b0, "R7", "loc rdy after reset", 32'(l_rdy), 0);

    // R7: counters at 1, history 0
    step(1, PC_A, 0, 0, 0, 0, "R7");
    step(1, 32'h0000_007c, 0, 0, 0, 0, "R7");

    // R3 / R4 upper end: 4 taken from 1 on the index predicted next
    for (int k = 0; k < 4; k++)
      step(0, 0, 1, 32'h100, 1, {5'd16, 5'b01111}, "R3");
    step(1, PC_A, 0, 0, 0, 0, "R4 high");

    // clear shared history with not-taken updates elsewhere
    for (int k = 0; k < 5; k++) step(0, 0, 1, 32'h104, 0, 10'd3, "R5");
    // R4 lower end: 4 not-taken from 1 at {16,0}
    for (int k = 0; k < 4; k++) step(0, 0, 1, 32'h104, 0, {5'd16, 5'd0}, "R4");
    step(1, PC_A, 0, 0, 0, 0, "R4 low");

    // R8: index taken from the port, PC unrelated
    step(0, 0, 1, 32'hdead_beec, 1, 10'h2aa, "R8");
    step(0, 0, 1, 32'h1234_5678, 1, 10'h2aa, "R8");
    step(1, 32'h0000_0054, 0, 0, 0, 0, "R8");

    // R9: predict and update the same entry in one cycle
    step(1, PC_A, 1, PC_A, 1, idx_g(PC_A), "R9");
    step(1, PC_A, 1, PC_A, 1, idx_g(PC_A), "R9");
    step(1, PC_A, 0, 0, 0, 0, "R9");

    // R5: per-branch history with two alternating PCs
    for (int k = 0; k < 8; k++) begin
      step(1, 32'h0000_0010, 1, 32'h0000_0010, 1, 10'(k), "R5");
      step(1, 32'h0000_0014, 1, 32'h0000_0014, 0, 10'(k + 3), "R5");
    end

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] rp, ru;
      logic [9:0]  ri;
      bit pv, uv, ut;
      rp = $urandom() & 32'h0000_00fc;
      ru = $urandom() & 32'h0000_00fc;
      ri = 10'($urandom());
      if (n % 3 == 0) ri = idx_g(rp);
      pv = ($urandom() % 4) != 0;
      uv = ($urandom() % 3) != 0;
      ut = ($urandom() % 5) < 3;
      step(pv, rp, uv, ru, ut, ri, "R3 R6 random");
    end

    step(0, 0, 0, 0, 0, 0, "R1 flush");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule